// File: doc/BRIEF.md
# Graphic LCD Host Bus Controller

This block is the processor-facing side of a 64-column graphic LCD segment driver. A host talks to it over an asynchronous 8-bit parallel bus. The bus has an enable strobe, a register-select line, a read/write line and three chip selects, two active-low and one active-high. The strobe is brought into the single system clock through a synchroniser. An access takes effect when the synchronised strobe falls.

Instruction bytes load a 3-bit page register, a 6-bit column counter, a 6-bit start-line register and a display-enable flag. Data writes and data reads go to a 512x8 display memory outside the block, addressed as page*64 + column. The column counter steps after every data access.

Data reads are pipelined through an output register, so the first read after an address change returns a stale byte. A status read returns busy, display-off and reset-active directly and needs no dummy read. After each accepted instruction or write, a short busy window follows, and commands that arrive in that window are dropped.

Top module: `glcd_host_if`

## Requirements
- R1: An access is acted on only when cs1_n=0, cs2_n=0 and cs3=1; with any chip select inactive, no state changes and the bus is not driven.
- R2: rs=0/rw=0 is an instruction, rs=1/rw=0 a RAM write, rs=0/rw=1 a status read, rs=1/rw=1 a data read.
- R3: Writes and instructions take effect on the synchronised falling edge of `en`; a RAM write stores `db_in` at address {page, column}.
- R4: Instruction byte 0011111d sets `disp_on` to d (1 = on) and changes no other state.
- R5: Byte 01cccccc loads the column, 10111ppp loads the page, 11ssssss loads the start line; any other instruction byte is ignored.
- R6: The column increments by one after every accepted data write or data read and wraps from 63 to 0; the page never changes except by instruction.
- R7: A data read drives the byte latched by the previous data read, then reloads that register from the current address; after reset this register holds 0x00.
- R8: The status byte is {busy, 0, display-off, reset-active, 0000} with busy at bit 7, display-off at bit 5 and reset-active at bit 4.
- R9: While `rst_n` is low, `disp_on` is 0, `start_line` is 0, status reads report reset-active and instructions have no effect.
- R10: Busy is high for BUSY_CYCLES (default 2) clocks after each accepted instruction or write; instructions, writes and data reads that arrive while busy are dropped.
- R11: `db_oe` is high only during a selected read (rw=1) with `en` high; otherwise the bus is released and `db_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, also reported in the status byte |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| en | input | 1 | Asynchronous host enable strobe |
| rs | input | 1 | Register select: 1 data, 0 instruction/status |
| rw | input | 1 | 1 read, 0 write |
| db_in | input | 8 | Host bus data into the block |
| db_out | output | 8 | Host bus data out of the block |
| db_oe | output | 1 | Output enable for the bus driver |
| ram_addr | output | 9 | Display memory address {page, column} |
| ram_wdata | output | 8 | Display memory write data |
| ram_we | output | 1 | Display memory write strobe, one clock |
| ram_re | output | 1 | Display memory read strobe; data expected next clock |
| ram_rdata | input | 8 | Display memory read data, registered |
| disp_on | output | 1 | Display-enable flag for the scan logic |
| start_line | output | 6 | Start-line register for the scan logic |

## Verification
The bench uses the default parameters: 6-bit column, 3-bit page, two synchroniser stages and a two-cycle busy window. With these values, a write at column 63 that wraps to column 0 of the same page can be reached in a few accesses. Two enable pulses two clocks apart then land the second access exactly inside the busy window, so the drop shows up as a column that advanced only once. The 512-byte memory model keeps the page-times-64 addressing visible through read-back.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

   typedef enum logic [2:0] {
      ACC_NONE   = 3'd0,
      ACC_INSTR  = 3'd1,
      ACC_WRITE  = 3'd2,
      ACC_STATUS = 3'd3,
      ACC_READ   = 3'd4
   } acc_e;

   typedef enum logic [2:0] {
      INS_NONE  = 3'd0,
      INS_DISP  = 3'd1,
      INS_COL   = 3'd2,
      INS_PAGE  = 3'd3,
      INS_START = 3'd4
   } ins_e;

   localparam int STAT_BUSY_BIT = 7;
   localparam int STAT_OFF_BIT  = 5;
   localparam int STAT_RST_BIT  = 4;

   function automatic logic [7:0] status_byte(input logic busy,
                                              input logic off,
                                              input logic in_rst);
      logic [7:0] s;
      s = 8'h00;
      s[STAT_BUSY_BIT] = busy;
      s[STAT_OFF_BIT]  = off;
      s[STAT_RST_BIT]  = in_rst;
      return s;
   endfunction

endpackage

// File: rtl/glcd_strobe_sync.sv
module glcd_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic level_o,
   output logic fall_o
);

   logic prev_q;

   generate
      if (STAGES < 0) begin : g_bad
         $error("glcd_strobe_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign level_o = strobe_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= strobe_i;
               for (int i = 1; i < STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign level_o = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_o;
   end

   assign fall_o = prev_q & ~level_o;

endmodule

// File: rtl/glcd_cmd_decode.sv
module glcd_cmd_decode
   import glcd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int COL_W  = 6,
   parameter int PAGE_W = 3,
   parameter int LINE_W = 6
) (
   input  logic              sel,
   input  logic              rs,
   input  logic              rw,
   input  logic [DATA_W-1:0] din,
   output acc_e              acc,
   output ins_e              ins,
   output logic              d_on,
   output logic [COL_W-1:0]  col_arg,
   output logic [PAGE_W-1:0] page_arg,
   output logic [LINE_W-1:0] line_arg
);

   localparam int FIELD_W = DATA_W - 2;
   localparam int PAGE_MAX = 3;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("glcd_cmd_decode: instruction codes need an 8-bit bus");
      end
      if (COL_W > FIELD_W || LINE_W > FIELD_W) begin : g_bad_field
         $error("glcd_cmd_decode: column or line wider than its field");
      end
      if (PAGE_W > PAGE_MAX || PAGE_W < 1) begin : g_bad_page
         $error("glcd_cmd_decode: page field must be 1 to 3 bits");
      end
   endgenerate

   always_comb begin
      acc = ACC_NONE;
      if (sel) begin
         case ({rs, rw})
            2'b00:   acc = ACC_INSTR;
            2'b10:   acc = ACC_WRITE;
            2'b01:   acc = ACC_STATUS;
            default: acc = ACC_READ;
         endcase
      end
   end

   always_comb begin
      ins = INS_NONE;
      case (din[7:6])
         2'b00: if (din[5:1] == 5'b11111) ins = INS_DISP;
         2'b01: ins = INS_COL;
         2'b10: if (din[5:3] == 3'b111)   ins = INS_PAGE;
         default: ins = INS_START;
      endcase
   end

   assign d_on     = din[0];
   assign col_arg  = din[COL_W-1:0];
   assign page_arg = din[PAGE_W-1:0];
   assign line_arg = din[LINE_W-1:0];

endmodule

// File: rtl/glcd_ctrl_regs.sv
module glcd_ctrl_regs
   import glcd_pkg::*;
#(
   parameter int COL_W       = 6,
   parameter int PAGE_W      = 3,
   parameter int LINE_W      = 6,
   parameter int BUSY_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall,
   input  acc_e              acc,
   input  ins_e              ins,
   input  logic              d_on,
   input  logic [COL_W-1:0]  col_arg,
   input  logic [PAGE_W-1:0] page_arg,
   input  logic [LINE_W-1:0] line_arg,
   output logic [PAGE_W-1:0] page_q,
   output logic [COL_W-1:0]  col_q,
   output logic [LINE_W-1:0] line_q,
   output logic              disp_on_q,
   output logic              busy,
   output logic              ram_we,
   output logic              ram_re
);

   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("glcd_ctrl_regs: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] busy_cnt_q;
   logic             take_instr;
   logic             take_write;
   logic             take_read;

   assign busy       = (busy_cnt_q != '0);
   assign take_instr = fall && !busy && (acc == ACC_INSTR) && (ins != INS_NONE);
   assign take_write = fall && !busy && (acc == ACC_WRITE);
   assign take_read  = fall && !busy && (acc == ACC_READ);
   assign ram_we     = take_write;
   assign ram_re     = take_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q    <= '0;
         col_q     <= '0;
         line_q    <= '0;
         disp_on_q <= 1'b0;
      end else begin
         if (take_write || take_read) begin
            col_q <= col_q + 1'b1;
         end
         if (take_instr) begin
            case (ins)
               INS_DISP:  disp_on_q <= d_on;
               INS_COL:   col_q     <= col_arg;
               INS_PAGE:  page_q    <= page_arg;
               INS_START: line_q    <= line_arg;
               default:   ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt_q <= '0;
      end else if (take_instr || take_write) begin
         busy_cnt_q <= CNT_W'(BUSY_CYCLES);
      end else if (busy) begin
         busy_cnt_q <= busy_cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/glcd_read_pipe.sv
module glcd_read_pipe
   import glcd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ram_re,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic              sel,
   input  logic              rs,
   input  logic              rw,
   input  logic              en,
   input  logic              busy,
   input  logic              disp_on,
   output logic [DATA_W-1:0] db_out,
   output logic              db_oe
);

   logic              pend_q;
   logic [DATA_W-1:0] out_q;
   logic [7:0]        stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         out_q  <= '0;
      end else begin
         pend_q <= ram_re;
         if (pend_q) out_q <= ram_rdata;
      end
   end

   assign stat  = status_byte(busy, !disp_on, !rst_n);
   assign db_oe = sel && rw && en;

   always_comb begin
      db_out = '0;
      if (db_oe) db_out = rs ? out_q : DATA_W'(stat);
   end

endmodule

// File: rtl/glcd_host_if.sv
module glcd_host_if
   import glcd_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int COL_W       = 6,
   parameter int PAGE_W      = 3,
   parameter int LINE_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int BUSY_CYCLES = 2,
   localparam int RAM_AW     = PAGE_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs1_n,
   input  logic              cs2_n,
   input  logic              cs3,
   input  logic              en,
   input  logic              rs,
   input  logic              rw,
   input  logic [DATA_W-1:0] db_in,
   output logic [DATA_W-1:0] db_out,
   output logic              db_oe,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              ram_we,
   output logic              ram_re,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              disp_on,
   output logic [LINE_W-1:0] start_line
);

   logic              sel;
   logic              en_level;
   logic              en_fall;
   acc_e              acc;
   ins_e              ins;
   logic              d_on;
   logic [COL_W-1:0]  col_arg;
   logic [PAGE_W-1:0] page_arg;
   logic [LINE_W-1:0] line_arg;
   logic [PAGE_W-1:0] page_q;
   logic [COL_W-1:0]  col_q;
   logic              busy_w;

   assign sel = !cs1_n && !cs2_n && cs3;

   glcd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (en),
      .level_o  (en_level),
      .fall_o   (en_fall)
   );

   glcd_cmd_decode #(
      .DATA_W (DATA_W), .COL_W (COL_W), .PAGE_W (PAGE_W), .LINE_W (LINE_W)
   ) u_dec (
      .sel      (sel),
      .rs       (rs),
      .rw       (rw),
      .din      (db_in),
      .acc      (acc),
      .ins      (ins),
      .d_on     (d_on),
      .col_arg  (col_arg),
      .page_arg (page_arg),
      .line_arg (line_arg)
   );

   glcd_ctrl_regs #(
      .COL_W (COL_W), .PAGE_W (PAGE_W), .LINE_W (LINE_W),
      .BUSY_CYCLES (BUSY_CYCLES)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall      (en_fall),
      .acc       (acc),
      .ins       (ins),
      .d_on      (d_on),
      .col_arg   (col_arg),
      .page_arg  (page_arg),
      .line_arg  (line_arg),
      .page_q    (page_q),
      .col_q     (col_q),
      .line_q    (start_line),
      .disp_on_q (disp_on),
      .busy      (busy_w),
      .ram_we    (ram_we),
      .ram_re    (ram_re)
   );

   glcd_read_pipe #(.DATA_W(DATA_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .ram_re    (ram_re),
      .ram_rdata (ram_rdata),
      .sel       (sel),
      .rs        (rs),
      .rw        (rw),
      .en        (en),
      .busy      (busy_w),
      .disp_on   (disp_on),
      .db_out    (db_out),
      .db_oe     (db_oe)
   );

   assign ram_addr  = {page_q, col_q};
   assign ram_wdata = db_in;

   logic unused_level;
   assign unused_level = en_level;

endmodule

// File: rtl/glcd_host_if_chk.sv
module glcd_host_if_chk #(
   parameter int DATA_W = 8,
   parameter int COL_W  = 6,
   parameter int PAGE_W = 3,
   parameter int LINE_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs1_n,
   input logic              cs2_n,
   input logic              cs3,
   input logic              en,
   input logic              rs,
   input logic              rw,
   input logic [DATA_W-1:0] db_out,
   input logic              db_oe,
   input logic              ram_we,
   input logic              ram_re,
   input logic              disp_on,
   input logic [LINE_W-1:0] start_line,
   input logic [COL_W-1:0]  col,
   input logic [PAGE_W-1:0] page,
   input logic              busy
);

   a_r1_we_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || ram_re) |-> (!cs1_n && !cs2_n && cs3));

   a_r2_we_is_data_write: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (rs && !rw));

   a_r6_col_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || ram_re) |=> (col == COL_W'($past(col) + 1'b1)));

   a_r6_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we || ram_re) |=> $stable(page));

   a_r8_status_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (db_oe && !rs) |-> (db_out[6] == 1'b0 && db_out[3:0] == 4'h0));

   a_r9_reset_state: assert property (@(posedge clk)
      (!rst_n && $past(!rst_n)) |-> (!disp_on && start_line == '0));

   a_r10_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> busy);

   a_r10_no_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(ram_we || ram_re));

   a_r11_drive_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      db_oe |-> (en && rw && !cs1_n && !cs2_n && cs3));

endmodule

bind glcd_host_if glcd_host_if_chk #(
   .DATA_W (DATA_W), .COL_W (COL_W), .PAGE_W (PAGE_W), .LINE_W (LINE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs1_n      (cs1_n),
   .cs2_n      (cs2_n),
   .cs3        (cs3),
   .en         (en),
   .rs         (rs),
   .rw         (rw),
   .db_out     (db_out),
   .db_oe      (db_oe),
   .ram_we     (ram_we),
   .ram_re     (ram_re),
   .disp_on    (disp_on),
   .start_line (start_line),
   .col        (col_q),
   .page       (page_q),
   .busy       (busy_w)
);

// File: tb/sim_glcd_host_if.sv
module sim_glcd_host_if;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       cs1_n = 1'b1, cs2_n = 1'b1, cs3 = 1'b0;
   logic       en = 1'b0, rs = 1'b0, rw = 1'b0;
   logic [7:0] db_in = 8'h00;
   logic [7:0] db_out;
   logic       db_oe;
   logic [8:0] ram_addr;
   logic [7:0] ram_wdata;
   logic       ram_we, ram_re;
   logic [7:0] ram_rdata;
   logic       disp_on;
   logic [5:0] start_line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   glcd_host_if u0 (
      .clk (clk), .rst_n (rst_n), .cs1_n (cs1_n), .cs2_n (cs2_n), .cs3 (cs3),
      .en (en), .rs (rs), .rw (rw), .db_in (db_in), .db_out (db_out),
      .db_oe (db_oe), .ram_addr (ram_addr), .ram_wdata (ram_wdata),
      .ram_we (ram_we), .ram_re (ram_re), .ram_rdata (ram_rdata),
      .disp_on (disp_on), .start_line (start_line)
   );

   logic [7:0] mem [512];
   always_ff @(posedge clk) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // one complete host access with chosen chip selects
   task automatic bus_op(input logic c1n, input logic c2n, input logic c3,
                         input logic r_s, input logic r_w, input logic [7:0] d,
                         output logic [7:0] got, output logic oe);
      @(negedge clk);
      cs1_n = c1n; cs2_n = c2n; cs3 = c3; rs = r_s; rw = r_w; db_in = d;
      repeat (2) @(negedge clk);
      en = 1'b1;
      repeat (3) @(negedge clk);
      got = db_out; oe = db_oe;
      en = 1'b0;
      repeat (6) @(negedge clk);
      cs1_n = 1'b1; cs2_n = 1'b1; cs3 = 1'b0;
   endtask

   task automatic op(input logic r_s, input logic r_w, input logic [7:0] d,
                     output logic [7:0] got);
      logic oe;
      bus_op(1'b0, 1'b0, 1'b1, r_s, r_w, d, got, oe);
   endtask

   // fields: rs, rw, data, kind (0 none, 1 bus, 2 disp_on, 3 start_line), expected
   localparam int NV = 22;
   localparam logic [19:0] VEC [NV] = '{
      {1'b0, 1'b0, 8'h3F, 2'd2, 8'h01},  // R4 display on
      {1'b0, 1'b1, 8'h00, 2'd1, 8'h00},  // R8 status, display on
      {1'b0, 1'b0, 8'hBA, 2'd0, 8'h00},  // page 2
      {1'b0, 1'b0, 8'h45, 2'd0, 8'h00},  // column 5
      {1'b1, 1'b0, 8'hA5, 2'd0, 8'h00},  // R3 write to 133
      {1'b1, 1'b0, 8'h3C, 2'd0, 8'h00},  // write to 134
      {1'b0, 1'b0, 8'h45, 2'd0, 8'h00},  // column 5
      {1'b1, 1'b1, 8'h00, 2'd1, 8'h00},  // R7 dummy read, reset value
      {1'b1, 1'b1, 8'h00, 2'd1, 8'hA5},
      {1'b1, 1'b1, 8'h00, 2'd1, 8'h3C},
      {1'b0, 1'b0, 8'hEA, 2'd3, 8'h2A},  // R5 start line 42
      {1'b0, 1'b0, 8'h3E, 2'd2, 8'h00},  // R4 display off
      {1'b0, 1'b0, 8'h3D, 2'd2, 8'h00},  // R5 invalid code ignored
      {1'b0, 1'b1, 8'h00, 2'd1, 8'h20},  // R8 status, display off
      {1'b0, 1'b0, 8'h88, 2'd0, 8'h00},  // R5 invalid page code ignored
      {1'b0, 1'b0, 8'h7F, 2'd0, 8'h00},  // column 63
      {1'b1, 1'b0, 8'h11, 2'd0, 8'h00},  // write to 191
      {1'b1, 1'b0, 8'h22, 2'd0, 8'h00},  // R6 wrap: write to 128
      {1'b0, 1'b0, 8'h7F, 2'd0, 8'h00},
      {1'b1, 1'b1, 8'h00, 2'd0, 8'h00},  // dummy
      {1'b1, 1'b1, 8'h00, 2'd1, 8'h11},
      {1'b1, 1'b1, 8'h00, 2'd1, 8'h22}   // R6 wrapped within page 2
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] got;
      logic       oe;
      #2 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9 reset state, R11 bus released
      chk("R9 disp_on after reset", {7'd0, disp_on}, 8'h00);
      chk("R9 start_line after reset", {2'd0, start_line}, 8'h00);
      chk("R11 db_oe idle", {7'd0, db_oe}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [19:0] v;
         v = VEC[i];
         op(v[19], v[18], v[17:10], got);
         case (v[9:8])
            2'd1: chk(v[19] ? "R7 data read" : "R8 status read", got, v[7:0]);
            2'd2: chk("R4 disp_on", {7'd0, disp_on}, v[7:0]);
            2'd3: chk("R5 start_line", {2'd0, start_line}, v[7:0]);
            default: ;
         endcase
      end

      // R1: deselected instructions have no effect
      bus_op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3F, got, oe);
      chk("R1 cs1_n high ignored", {7'd0, disp_on}, 8'h00);
      bus_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3F, got, oe);
      chk("R1 cs3 low ignored", {7'd0, disp_on}, 8'h00);
      // R11: deselected read does not drive
      bus_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, got, oe);
      chk("R11 deselected read oe", {7'd0, oe}, 8'h00);
      // R11: selected read with enable low does not drive
      @(negedge clk);
      cs1_n = 1'b0; cs2_n = 1'b0; cs3 = 1'b1; rs = 1'b0; rw = 1'b1;
      @(negedge clk);
      chk("R11 enable low oe", {7'd0, db_oe}, 8'h00);
      cs1_n = 1'b1; cs2_n = 1'b1; cs3 = 1'b0;

      // R10: second write two clocks after the first is dropped
      op(1'b0, 1'b0, 8'h45, got);
      @(negedge clk);
      cs1_n = 1'b0; cs2_n = 1'b0; cs3 = 1'b1; rs = 1'b1; rw = 1'b0; db_in = 8'h77;
      repeat (2) @(negedge clk);
      en = 1'b1; @(negedge clk);
      en = 1'b0; @(negedge clk);
      en = 1'b1; @(negedge clk);
      en = 1'b0;
      repeat (8) @(negedge clk);
      cs1_n = 1'b1; cs2_n = 1'b1; cs3 = 1'b0;
      op(1'b0, 1'b0, 8'h45, got);
      op(1'b1, 1'b1, 8'h00, got);
      op(1'b1, 1'b1, 8'h00, got);
      chk("R10 first write taken", got, 8'h77);
      op(1'b1, 1'b1, 8'h00, got);
      chk("R10 dropped write left next column", got, 8'h3C);

      // R9: reset while active
      op(1'b0, 1'b0, 8'h3F, got);
      chk("R4 display on before reset", {7'd0, disp_on}, 8'h01);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 disp_on in reset", {7'd0, disp_on}, 8'h00);
      chk("R9 start_line in reset", {2'd0, start_line}, 8'h00);
      op(1'b0, 1'b1, 8'h00, got);
      chk("R9 status in reset", got, 8'h30);
      op(1'b0, 1'b0, 8'h3F, got);
      chk("R9 instruction ignored in reset", {7'd0, disp_on}, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      op(1'b0, 1'b1, 8'h00, got);
      chk("R8 status after reset", got, 8'h20);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule